// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer whose write port and read port each run on their own clock. The two clocks may be unrelated or may be one and the same net. Pointers cross between the two domains in Gray code through two-flop synchronizers. Empty and the almost-empty level are judged on the read side. Full, half-full and the almost-full level are judged on the write side. The storage depth is a power-of-two parameter: 256 words by default, with 512, 1024 and 4096 also intended.

A static mode input picks how reads behave. In standard mode, a read request moves the next word into the output register on the read-clock edge, and the read-side status bit means "empty". In fall-through mode, the oldest word is placed on the output without any request, and the status bit means "no word presented". The write-side status bit means "full" in both modes.

A configuration strobe sent with a write sends that word's low bits to the two threshold registers in turn instead of into storage. Reset brings both thresholds back to their defaults. A parameter adds a second stage to the empty and full status bits. With it, those bits still rise at once but fall one clock later. An output enable forces the data bus to zero when it is low.

Top module: `cdc_fifo_flags`

## Requirements
- R1: Words leave the buffer in the order they were written, with all 18 bits intact. In standard mode a word appears on `rd_data` just after the `rd_clk` edge at which `rd_en` was sampled high.
- R2: A write while the buffer holds DEPTH words is discarded. Stored contents and the write position do not change.
- R3: A read request while the buffer is empty (standard mode) is discarded. `rd_data` keeps its value, and the next word written is the next word read.
- R4: In standard mode `rd_stat` is 1 exactly when no word is stored. It goes to 1 on the read edge that removes the last word. `wr_stat` is 1 once DEPTH words are stored.
- R5: With the clocks tied, `rd_stat` falls on the 2nd `rd_clk` edge after the write edge when FLAG_STAGES=1, and on the 3rd when FLAG_STAGES=2. Both variants raise it on the same edge.
- R6: `half_full` is 1 while the write-side occupancy exceeds DEPTH/2.
- R7: `almost_empty` is 1 while the read-side occupancy is at or below the empty threshold (default 7).
- R8: `almost_full` is 1 while the free space (DEPTH minus write-side occupancy) is at or below the full threshold (default 7).
- R9: A `wr_clk` edge with `wr_en` and `cfg_ld` both high does not store the word. Its low log2(DEPTH) bits go to the empty threshold on the first such edge, to the full threshold on the second, and alternate after that.
- R10: Reset empties the buffer and restores both thresholds to their defaults.
- R11: In fall-through mode (`fwft_mode`=1) the oldest word appears on `rd_data` with no request, and `rd_stat`=0 signals it. A read moves the next word up. `rd_stat` goes to 1 on the edge that takes the last word, and it never falls without a read.
- R12: While `out_en` is 0, `rd_data` is all zeros. Raising `out_en` shows the held word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| fwft_mode | input | 1 | 0 standard read timing, 1 fall-through; static after reset |
| wr_en | input | 1 | Write request |
| cfg_ld | input | 1 | Steer writes to the threshold registers |
| wr_data | input | 18 | Write word |
| rd_en | input | 1 | Read request |
| out_en | input | 1 | Output enable; 0 forces `rd_data` to zero |
| rd_data | output | 18 | Read word |
| rd_stat | output | 1 | Empty (standard) or no-word-presented (fall-through) |
| wr_stat | output | 1 | Full |
| half_full | output | 1 | Occupancy above half |
| almost_empty | output | 1 | Occupancy at or below empty threshold |
| almost_full | output | 1 | Free space at or below full threshold |

## Verification
The ordering path is driven with all-ones, all-zeros, alternating-bit and single-bit words, so that a swapped, stuck or shifted data bit shows up. A full fill-and-drain walk with a different value per address catches aliasing between locations. Each flag is probed one word either side of its threshold, with default and with loaded thresholds. This tells a correct compare from an off-by-one one or a strict-versus-inclusive one. A single-stage and a double-stage copy are run side by side on one stimulus, so that a missing or misplaced status stage appears as a different count of edges.

// File: rtl/cdc_fifo_pkg.sv
package cdc_fifo_pkg;
  localparam int unsigned WORD_W = 18;

  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/cdc_fifo_rst_sync.sv
module cdc_fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/cdc_fifo_ptr_sync.sv
module cdc_fifo_ptr_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] gray_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  assign gray_out = sync_q;
endmodule

// File: rtl/cdc_fifo_wr_ctl.sv
module cdc_fifo_wr_ctl #(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned FLAG_STAGES = 1,
  parameter int unsigned AE_DEF      = 7,
  parameter int unsigned AF_DEF      = 7,
  localparam int unsigned AW         = $clog2(DEPTH),
  localparam int unsigned PW         = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          cfg_ld,
  input  logic [AW-1:0] cfg_val,
  input  logic [PW-1:0] rgray_s,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [PW-1:0] wgray,
  output logic          full_core,
  output logic          full_stat,
  output logic          half_full,
  output logic          almost_full,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off,
  output logic [PW-1:0] wr_level
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);

  logic [PW-1:0] wbin_q, wbin_d;
  logic [PW-1:0] wgray_q, wgray_d;
  logic          sel_af_q, sel_af_d;
  logic [AW-1:0] ae_off_q, ae_off_d;
  logic [AW-1:0] af_off_q, af_off_d;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] free_cnt;
  logic          push;
  logic          load;

  // Gray to binary for the synchronized read pointer
  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign wr_level  = wbin_q - rbin_s;
  assign full_core = (wr_level == FULL_LVL);
  assign free_cnt  = FULL_LVL - wr_level;
  assign push      = wr_en & ~cfg_ld & ~full_core;
  assign load      = wr_en & cfg_ld;

  always_comb begin
    wbin_d   = wbin_q + {{(PW-1){1'b0}}, push};
    wgray_d  = wbin_d ^ (wbin_d >> 1);
    sel_af_d = load ? ~sel_af_q : sel_af_q;
    ae_off_d = (load && !sel_af_q) ? cfg_val : ae_off_q;
    af_off_d = (load &&  sel_af_q) ? cfg_val : af_off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q   <= '0;
      wgray_q  <= '0;
      sel_af_q <= 1'b0;
      ae_off_q <= AW'(AE_DEF);
      af_off_q <= AW'(AF_DEF);
    end else begin
      wbin_q   <= wbin_d;
      wgray_q  <= wgray_d;
      sel_af_q <= sel_af_d;
      ae_off_q <= ae_off_d;
      af_off_q <= af_off_d;
    end
  end

  generate
    if (FLAG_STAGES > 1) begin : g_full_dbl
      logic hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= full_core;
      end
      assign full_stat = full_core | hold_q;
    end else begin : g_full_sgl
      assign full_stat = full_core;
    end
  endgenerate

  assign mem_we      = push;
  assign mem_waddr   = wbin_q[AW-1:0];
  assign wgray       = wgray_q;
  assign half_full   = (wr_level > HALF_LVL);
  assign almost_full = (free_cnt <= {1'b0, af_off_q});
  assign ae_off      = ae_off_q;
  assign af_off      = af_off_q;
endmodule

// File: rtl/cdc_fifo_rd_ctl.sv
module cdc_fifo_rd_ctl
  import cdc_fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned FLAG_STAGES = 1,
  localparam int unsigned AW         = $clog2(DEPTH),
  localparam int unsigned PW         = AW + 1,
  localparam int unsigned LW         = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              fwft_mode,
  input  logic [PW-1:0]     wgray_s,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [AW-1:0]     ae_off,
  output logic [AW-1:0]     mem_raddr,
  output logic [PW-1:0]     rgray,
  output logic [WORD_W-1:0] rd_word,
  output logic              empty_core,
  output logic              empty_stat,
  output logic              almost_empty,
  output logic              out_valid
);
  rd_mode_e          mode;
  logic [PW-1:0]     wbin_s;
  logic [PW-1:0]     rbin_q, rbin_d;
  logic [PW-1:0]     rgray_q, rgray_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;
  logic [PW-1:0]     mem_level;
  logic [LW-1:0]     rd_level;
  logic              mem_empty;
  logic              take;

  assign mode = rd_mode_e'(fwft_mode);

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign mem_level = wbin_s - rbin_q;
  assign mem_empty = (mem_level == '0);

  always_comb begin
    if (mode == RD_FWFT) begin
      take    = ~mem_empty & (~valid_q | rd_en);
      valid_d = take ? 1'b1 : (rd_en ? 1'b0 : valid_q);
    end else begin
      take    = rd_en & ~mem_empty;
      valid_d = 1'b0;
    end
    rbin_d  = rbin_q + {{(PW-1){1'b0}}, take};
    rgray_d = rbin_d ^ (rbin_d >> 1);
    word_d  = take ? mem_rdata : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign rd_level   = {1'b0, mem_level} +
                      {{PW{1'b0}}, (mode == RD_FWFT) & valid_q};
  assign empty_core = (mode == RD_FWFT) ? ~valid_q : mem_empty;

  generate
    if (FLAG_STAGES > 1) begin : g_empty_dbl
      logic hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b1;
        else        hold_q <= empty_core;
      end
      assign empty_stat = empty_core | hold_q;
    end else begin : g_empty_sgl
      assign empty_stat = empty_core;
    end
  endgenerate

  assign almost_empty = (rd_level <= {2'b00, ae_off});
  assign mem_raddr    = rbin_q[AW-1:0];
  assign rgray        = rgray_q;
  assign rd_word      = word_q;
  assign out_valid    = valid_q;
endmodule

// File: rtl/cdc_fifo_flags.sv
module cdc_fifo_flags
  import cdc_fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned FLAG_STAGES = 1,
  parameter int unsigned AE_DEF      = 7,
  parameter int unsigned AF_DEF      = 7
) (
  input  logic        wr_clk,
  input  logic        rd_clk,
  input  logic        rst_n,
  input  logic        fwft_mode,
  input  logic        wr_en,
  input  logic        cfg_ld,
  input  logic [17:0] wr_data,
  input  logic        rd_en,
  input  logic        out_en,
  output logic [17:0] rd_data,
  output logic        rd_stat,
  output logic        wr_stat,
  output logic        half_full,
  output logic        almost_empty,
  output logic        almost_full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic              wr_rst_s, rd_rst_s;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [WORD_W-1:0] mem_rdata;
  logic [WORD_W-1:0] rd_word;
  logic [AW-1:0]     ae_off, af_off;
  logic [PW-1:0]     wr_level;
  logic              full_core, empty_core, out_valid;

  logic [WORD_W-1:0] mem_q [DEPTH];

  cdc_fifo_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_s));
  cdc_fifo_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_s));

  cdc_fifo_ptr_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_s), .gray_in(wgray), .gray_out(wgray_s)
  );
  cdc_fifo_ptr_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_s), .gray_in(rgray), .gray_out(rgray_s)
  );

  cdc_fifo_wr_ctl #(
    .DEPTH(DEPTH), .FLAG_STAGES(FLAG_STAGES), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)
  ) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_s), .wr_en(wr_en), .cfg_ld(cfg_ld),
    .cfg_val(wr_data[AW-1:0]), .rgray_s(rgray_s), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .wgray(wgray), .full_core(full_core),
    .full_stat(wr_stat), .half_full(half_full), .almost_full(almost_full),
    .ae_off(ae_off), .af_off(af_off), .wr_level(wr_level)
  );

  cdc_fifo_rd_ctl #(
    .DEPTH(DEPTH), .FLAG_STAGES(FLAG_STAGES)
  ) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_s), .rd_en(rd_en), .fwft_mode(fwft_mode),
    .wgray_s(wgray_s), .mem_rdata(mem_rdata), .ae_off(ae_off),
    .mem_raddr(mem_raddr), .rgray(rgray), .rd_word(rd_word),
    .empty_core(empty_core), .empty_stat(rd_stat),
    .almost_empty(almost_empty), .out_valid(out_valid)
  );

  // Storage: written on the write clock, read combinationally by address
  always_ff @(posedge wr_clk) begin
    if (mem_we) mem_q[mem_waddr] <= wr_data;
  end

  assign mem_rdata = mem_q[mem_raddr];
  assign rd_data   = out_en ? rd_word : '0;
endmodule

// File: rtl/cdc_fifo_flags_chk.sv
module cdc_fifo_flags_chk #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst_s,
  input logic          rd_rst_s,
  input logic          fwft_mode,
  input logic          wr_en,
  input logic          cfg_ld,
  input logic          rd_en,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [17:0]   rd_word,
  input logic          full_core,
  input logic          empty_core,
  input logic          out_valid,
  input logic          half_full,
  input logic          almost_full,
  input logic [AW-1:0] af_off,
  input logic [PW-1:0] wr_level
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [AW-1:0] HALF_OFF = AW'(DEPTH / 2);

  p_gray_step_r1: assert property (@(posedge wr_clk) disable iff (!wr_rst_s)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_no_overflow_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_s)
    (full_core && wr_en && !cfg_ld) |=> $stable(wgray));

  p_level_bound_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_s)
    wr_level <= FULL_LVL);

  p_no_underflow_r3: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    (!fwft_mode && empty_core && rd_en) |=> ($stable(rgray) && $stable(rd_word)));

  p_hf_under_af_r6: assert property (@(posedge wr_clk) disable iff (!wr_rst_s)
    (almost_full && (af_off < HALF_OFF)) |-> half_full);

  p_load_not_stored_r9: assert property (@(posedge wr_clk) disable iff (!wr_rst_s)
    (wr_en && cfg_ld) |=> $stable(wgray));

  p_ready_drop_r11: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    (fwft_mode && $fell(out_valid)) |-> $past(rd_en));
endmodule

bind cdc_fifo_flags cdc_fifo_flags_chk #(.DEPTH(DEPTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_s(wr_rst_s), .rd_rst_s(rd_rst_s),
  .fwft_mode(fwft_mode), .wr_en(wr_en), .cfg_ld(cfg_ld), .rd_en(rd_en),
  .wgray(wgray), .rgray(rgray), .rd_word(rd_word), .full_core(full_core),
  .empty_core(empty_core), .out_valid(out_valid), .half_full(half_full),
  .almost_full(almost_full), .af_off(af_off), .wr_level(wr_level)
);

// File: tb/cdc_fifo_flags_bench.sv
module cdc_fifo_flags_bench;
  localparam int DEPTH = 256;

  logic        clk, rst_n, fwft_mode, wr_en, cfg_ld, rd_en, out_en;
  logic [17:0] wr_data;
  logic [17:0] rd_data, rd_data_d;
  logic        rd_stat, wr_stat, half_full, almost_empty, almost_full;
  logic        rd_stat_d, wr_stat_d, half_full_d, almost_empty_d, almost_full_d;

  int n_chk = 0;
  int n_err = 0;

  cdc_fifo_flags #(.DEPTH(DEPTH), .FLAG_STAGES(1)) u_cdc_fifo_flags (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wr_en(wr_en), .cfg_ld(cfg_ld), .wr_data(wr_data), .rd_en(rd_en),
    .out_en(out_en), .rd_data(rd_data), .rd_stat(rd_stat), .wr_stat(wr_stat),
    .half_full(half_full), .almost_empty(almost_empty),
    .almost_full(almost_full)
  );

  cdc_fifo_flags #(.DEPTH(DEPTH), .FLAG_STAGES(2)) u_cdc_fifo_flags_dbl (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wr_en(wr_en), .cfg_ld(cfg_ld), .wr_data(wr_data), .rd_en(rd_en),
    .out_en(out_en), .rd_data(rd_data_d), .rd_stat(rd_stat_d),
    .wr_stat(wr_stat_d), .half_full(half_full_d),
    .almost_empty(almost_empty_d), .almost_full(almost_full_d)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; fwft_mode = mode;
    wr_en = 1'b0; cfg_ld = 1'b0; rd_en = 1'b0; out_en = 1'b1; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic push(input logic [17:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop(output logic [17:0] d);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    apply_reset(1'b0);
    chk("R10 empty after reset", rd_stat, 1);
    chk("R4 not full after reset", wr_stat, 0);
    chk("R7 almost_empty after reset", almost_empty, 1);
    chk("R8 almost_full after reset", almost_full, 0);
    chk("R6 half_full after reset", half_full, 0);
    chk("R10 rd_data after reset", rd_data, 0);
    chk("R5 dbl empty after reset", rd_stat_d, 1);
  endtask

  task automatic t_order();
    logic [17:0] pat [5] = '{18'h3FFFF, 18'h00000, 18'h2AAAA, 18'h15555, 18'h00001};
    logic [17:0] got;
    for (int i = 0; i < 5; i++) push(pat[i]);
    repeat (4) @(negedge clk);
    chk("R4 not empty after writes", rd_stat, 0);
    for (int i = 0; i < 5; i++) begin
      pop(got);
      chk("R1 word order", got, pat[i]);
    end
    chk("R4 empty after last read", rd_stat, 1);
    pop(got);
    chk("R3 rd_data holds on empty read", got, 18'h00001);
    push(18'h12345);
    repeat (4) @(negedge clk);
    pop(got);
    chk("R3 pointer unchanged by empty read", got, 18'h12345);
    chk("R4 empty again", rd_stat, 1);
  endtask

  task automatic t_latency();
    int lat_s = -1;
    int lat_d = -1;
    logic [17:0] got;
    wr_en = 1'b1; wr_data = 18'h0BEEF;
    @(negedge clk);
    wr_en = 1'b0;
    for (int e = 0; e < 8; e++) begin
      if (lat_s < 0 && rd_stat == 1'b0) lat_s = e;
      if (lat_d < 0 && rd_stat_d == 1'b0) lat_d = e;
      @(negedge clk);
    end
    chk("R5 single-stage deassert edges", lat_s, 2);
    chk("R5 double-stage deassert edges", lat_d, 3);
    pop(got);
    chk("R1 latency word", got, 18'h0BEEF);
    chk("R5 single asserts on last read", rd_stat, 1);
    chk("R5 double asserts on last read", rd_stat_d, 1);
  endtask

  task automatic t_fill();
    logic [17:0] got;
    int bad = 0;
    apply_reset(1'b0);
    for (int n = 1; n <= DEPTH; n++) begin
      push(18'((n - 1) * 37 + 5));
      if (n == 128) chk("R6 half_full at half", half_full, 0);
      if (n == 129) chk("R6 half_full above half", half_full, 1);
      if (n == 248) chk("R8 almost_full free 8", almost_full, 0);
      if (n == 249) chk("R8 almost_full free 7", almost_full, 1);
      if (n == DEPTH - 1) chk("R4 not full at DEPTH-1", wr_stat, 0);
      if (n == DEPTH) chk("R4 full at DEPTH", wr_stat, 1);
    end
    push(18'h3ABCD);
    chk("R2 still full after extra write", wr_stat, 1);
    repeat (4) @(negedge clk);
    for (int j = 1; j <= DEPTH; j++) begin
      pop(got);
      if (got !== 18'((j - 1) * 37 + 5)) bad++;
      if (DEPTH - j == 8) chk("R7 almost_empty level 8", almost_empty, 0);
      if (DEPTH - j == 7) chk("R7 almost_empty level 7", almost_empty, 1);
    end
    chk("R1 full drain mismatches", bad, 0);
    chk("R2 extra write not stored", rd_stat, 1);
  endtask

  task automatic t_load();
    apply_reset(1'b0);
    cfg_ld = 1'b1;
    push(18'd3);
    push(18'd20);
    cfg_ld = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 load words not stored", rd_stat, 1);
    for (int i = 0; i < 3; i++) push(18'(i));
    repeat (4) @(negedge clk);
    chk("R9 loaded empty threshold level 3", almost_empty, 1);
    push(18'd3);
    repeat (4) @(negedge clk);
    chk("R9 loaded empty threshold level 4", almost_empty, 0);
    for (int n = 5; n <= 235; n++) push(18'(n));
    chk("R9 loaded full threshold free 21", almost_full, 0);
    push(18'd236);
    chk("R9 loaded full threshold free 20", almost_full, 1);
    apply_reset(1'b0);
    chk("R10 empty after mid-fill reset", rd_stat, 1);
    for (int i = 0; i < 7; i++) push(18'(i));
    repeat (4) @(negedge clk);
    chk("R10 default empty threshold level 7", almost_empty, 1);
    push(18'd7);
    repeat (4) @(negedge clk);
    chk("R10 default empty threshold level 8", almost_empty, 0);
  endtask

  task automatic t_fwft();
    logic [17:0] got;
    apply_reset(1'b1);
    chk("R11 no word after reset", rd_stat, 1);
    push(18'h1A1A1);
    push(18'h2B2B2);
    push(18'h0C3C3);
    repeat (6) @(negedge clk);
    chk("R11 ready without read", rd_stat, 0);
    chk("R11 first word falls through", rd_data, 18'h1A1A1);
    pop(got);
    chk("R11 second word", got, 18'h2B2B2);
    pop(got);
    chk("R11 third word", got, 18'h0C3C3);
    chk("R11 still ready on last word", rd_stat, 0);
    pop(got);
    chk("R11 not ready after last taken", rd_stat, 1);
  endtask

  task automatic t_oe();
    push(18'h25A5A);
    repeat (6) @(negedge clk);
    out_en = 1'b0;
    #1;
    chk("R12 idle value with out_en low", rd_data, 0);
    out_en = 1'b1;
    #1;
    chk("R12 word back with out_en high", rd_data, 18'h25A5A);
  endtask

  initial begin
    rst_n = 1'b0; fwft_mode = 1'b0; wr_en = 1'b0; cfg_ld = 1'b0;
    rd_en = 1'b0; out_en = 1'b1; wr_data = '0;
    t_reset();
    t_order();
    t_latency();
    t_fill();
    t_load();
    t_fwft();
    t_oe();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule